// File: doc/BRIEF.md
# Serial Wiper Step Unit

This unit nudges the 8-bit wiper counter of one of four potentiometers up or down by a single tap for every clock pulse on the serial interface. The serial frame decoder, which runs elsewhere, recognises the step command and raises a one-cycle enable with the two-bit pot select. From then until chip select is released, each rising edge of the serial clock (SCK) moves that pot's wiper. The serial data line gives the direction: high means up, low means down. Up and down pulses may be mixed freely, and there is no limit on how many arrive.

SCK, the data line and the active-low chip select come from off-chip. The unit passes all three through synchronisers into the system clock domain and detects SCK rising edges there. It holds no wiper state of its own. It reads the selected pot's current value from the shared register bank through `cur_wiper`, and it returns each new value on a one-cycle write strobe together with the pot index. The bank must present `cur_wiper` for the pot that `upd_pot` names. The counter stops at 255 and at 0 and never wraps.

Top module: `wiper_step_unit`

## Requirements
- R1: After reset `upd_valid` is 0. SCK pulses that arrive before any step command produce no update.
- R2: A step command is accepted only when `cmd_valid` is high while the synchronised chip select is low (asserted). `cmd_pot` is latched at that moment and names the pot that every later update writes.
- R3: When the data line is high at an SCK rising edge, the selected wiper value goes up by one.
- R4: When the data line is low at an SCK rising edge, the selected wiper value goes down by one.
- R5: An up step at 255 leaves the value at 255. It never wraps to 0.
- R6: A down step at 0 leaves the value at 0. It never wraps to 255.
- R7: Each SCK rising edge gives exactly one `upd_valid` strobe, one system clock wide. SCK falling edges and SCK held high give none.
- R8: Once chip select is deasserted (high), stepping is disabled. SCK pulses after that cause no update until a new command is accepted.
- R9: Only the pot named at command time is written. The other three wiper values are unchanged.
- R10: A sequence of mixed up and down pulses of any length leaves the wiper at its start value plus the number of up pulses minus the number of down pulses, limited at each step to the range 0 to 255.
- R11: If `cmd_valid` arrives while chip select is deasserted, it is ignored. Later SCK pulses with chip select low still produce no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data line, giving the step direction (1 = up) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| cmd_valid | input | 1 | One-cycle step-command strobe from the frame decoder |
| cmd_pot | input | 2 | Pot select that comes with the command |
| cur_wiper | input | 8 | Current bank value of the pot named by `upd_pot` |
| upd_valid | output | 1 | Write strobe to the register bank |
| upd_pot | output | 2 | Pot index for the write and for the `cur_wiper` read |
| upd_wiper | output | 8 | New wiper value to write |

## Verification
The bench drives the wiper to both ends and keeps stepping. A design that wrapped around would show 0 after 255, or 255 after 0. It holds SCK high for many system cycles and counts the strobes. A level-sensitive or double-triggering design would write the wiper more than once per pulse. It pulses SCK after chip select is released, and after a command given while chip select was high. Either case exposes a design that stays enabled, or one that arms without checking chip select. It also checks all four bank entries after every scenario, to catch writes to the wrong pot and direction inversions in mixed sequences.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;

    localparam int WIPER_W  = 8;
    localparam int POT_SEL_W = 2;

    typedef logic [WIPER_W-1:0]   wiper_t;
    typedef logic [POT_SEL_W-1:0] pot_sel_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    localparam wiper_t WIPER_MAX = {WIPER_W{1'b1}};
    localparam wiper_t WIPER_MIN = '0;

    function automatic wiper_t sat_step(input wiper_t cur, input step_dir_e dir);
        wiper_t nxt;
        if (dir == DIR_UP)
            nxt = (cur == WIPER_MAX) ? cur : cur + wiper_t'(1);
        else
            nxt = (cur == WIPER_MIN) ? cur : cur - wiper_t'(1);
        return nxt;
    endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= rst_val;
        else     stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= rst_val;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
    import wiper_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_s,
    input  logic      si_s,
    input  logic      cs_n_s,
    input  logic      cmd_valid,
    input  pot_sel_t  cmd_pot,
    output logic      armed,
    output logic      step_en,
    output step_dir_e step_dir,
    output pot_sel_t  sel_pot
);

    logic sck_d;
    logic sck_rise;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            sel_pot <= '0;
        end else if (cs_n_s) begin
            armed   <= 1'b0;
        end else if (cmd_valid) begin
            armed   <= 1'b1;
            sel_pot <= cmd_pot;
        end
    end

    assign step_en  = armed & sck_rise;
    assign step_dir = si_s ? DIR_UP : DIR_DOWN;

    // stepping must be off in any cycle after chip select was seen high
    assert_disarm_on_cs_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !armed);

    // arming only by a command taken while selected
    assert_arm_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(cmd_valid) && !$past(cs_n_s));

endmodule

// File: rtl/wiper_step_datapath.sv
module wiper_step_datapath
    import wiper_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  step_dir_e step_dir,
    input  wiper_t    cur_wiper,
    output logic      upd_valid,
    output wiper_t    upd_wiper
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid <= 1'b0;
            upd_wiper <= '0;
        end else begin
            upd_valid <= step_en;
            if (step_en) upd_wiper <= sat_step(cur_wiper, step_dir);
        end
    end

    assert_single_tap_R10: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_wiper == $past(cur_wiper)) ||
                      (upd_wiper == wiper_t'($past(cur_wiper) + wiper_t'(1))) ||
                      (upd_wiper == wiper_t'($past(cur_wiper) - wiper_t'(1))));

    assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (rst)
        upd_valid && ($past(cur_wiper) == WIPER_MAX) |-> upd_wiper >= WIPER_MAX - wiper_t'(1));

    assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (rst)
        upd_valid && ($past(cur_wiper) == WIPER_MIN) |-> upd_wiper <= wiper_t'(1));

endmodule

// File: rtl/wiper_step_unit.sv
module wiper_step_unit
    import wiper_step_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck,
    input  logic                 si,
    input  logic                 cs_n,
    input  logic                 cmd_valid,
    input  logic [POT_SEL_W-1:0] cmd_pot,
    input  logic [WIPER_W-1:0]   cur_wiper,
    output logic                 upd_valid,
    output logic [POT_SEL_W-1:0] upd_pot,
    output logic [WIPER_W-1:0]   upd_wiper
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_s;
    logic              armed;
    logic              step_en;
    step_dir_e         step_dir;

    wiper_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .rst_val  (3'b100),
        .async_in ({cs_n, si, sck}),
        .sync_out (pins_s)
    );

    wiper_step_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (pins_s[0]),
        .si_s      (pins_s[1]),
        .cs_n_s    (pins_s[2]),
        .cmd_valid (cmd_valid),
        .cmd_pot   (cmd_pot),
        .armed     (armed),
        .step_en   (step_en),
        .step_dir  (step_dir),
        .sel_pot   (upd_pot)
    );

    wiper_step_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .step_dir  (step_dir),
        .cur_wiper (cur_wiper),
        .upd_valid (upd_valid),
        .upd_wiper (upd_wiper)
    );

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !upd_valid);

    assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> !upd_valid);

    assert_pot_held_R9: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $stable(upd_pot));

endmodule

// File: tb/wiper_step_unit_tb_top.sv
module wiper_step_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       sck, si, cs_n, cmd_valid;
    logic [1:0] cmd_pot;
    logic [7:0] cur_wiper;
    logic       upd_valid;
    logic [1:0] upd_pot;
    logic [7:0] upd_wiper;

    logic [7:0] bank [4];
    int         upd_count;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #4 clk = ~clk;

    wiper_step_unit dut_i (
        .clk(clk), .rst(rst), .sck(sck), .si(si), .cs_n(cs_n),
        .cmd_valid(cmd_valid), .cmd_pot(cmd_pot), .cur_wiper(cur_wiper),
        .upd_valid(upd_valid), .upd_pot(upd_pot), .upd_wiper(upd_wiper)
    );

    assign cur_wiper = bank[upd_pot];

    always @(posedge clk) begin
        if (upd_valid) begin
            bank[upd_pot] <= upd_wiper;
            upd_count     <= upd_count + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic preset(input int v0, input int v1, input int v2, input int v3);
        @(negedge clk);
        bank[0] = 8'(v0); bank[1] = 8'(v1); bank[2] = 8'(v2); bank[3] = 8'(v3);
        upd_count = 0;
    endtask

    task automatic check_bank(input string req, input int v0, input int v1,
                              input int v2, input int v3);
        @(negedge clk);
        check(req, bank[0], v0);
        check(req, bank[1], v1);
        check(req, bank[2], v2);
        check(req, bank[3], v3);
    endtask

    task automatic pulse(input bit dir, input int high_cycles = 6);
        @(negedge clk);
        si = dir;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (high_cycles) @(negedge clk);
        sck = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic select_and_cmd(input int pot);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1; cmd_pot = 2'(pot);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1; sck = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        check("R1 upd_valid after reset", upd_valid, 0);
        preset(10, 20, 30, 40);
        @(negedge clk); cs_n = 1'b0;
        pulse(1); pulse(0); pulse(1);
        check("R1 no strobes without command", upd_count, 0);
        check_bank("R1 bank untouched", 10, 20, 30, 40);
        deselect();
    endtask

    task automatic t_cmd_while_deselected();
        preset(10, 20, 30, 40);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_pot = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        pulse(1); pulse(1);
        check("R11 ignored command gives no strobe", upd_count, 0);
        check_bank("R11 bank untouched", 10, 20, 30, 40);
        deselect();
    endtask

    task automatic t_increment();
        preset(10, 20, 30, 40);
        select_and_cmd(2);
        pulse(1); pulse(1); pulse(1);
        check("R7 one strobe per pulse", upd_count, 3);
        check_bank("R3/R9/R2 increment pot 2 only", 10, 20, 33, 40);
        deselect();
    endtask

    task automatic t_decrement();
        preset(10, 20, 30, 40);
        select_and_cmd(1);
        for (int k = 0; k < 5; k++) pulse(0);
        check("R7 one strobe per pulse", upd_count, 5);
        check_bank("R4/R9 decrement pot 1 only", 10, 15, 30, 40);
        deselect();
    endtask

    task automatic t_long_high();
        preset(10, 20, 30, 40);
        select_and_cmd(0);
        pulse(1, 40);
        check("R7 held-high SCK gives one strobe", upd_count, 1);
        check_bank("R7 single step", 11, 20, 30, 40);
        deselect();
    endtask

    task automatic t_sat_top();
        preset(0, 0, 0, 254);
        select_and_cmd(3);
        pulse(1); pulse(1); pulse(1);
        check_bank("R5 saturate at 255", 0, 0, 0, 255);
        deselect();
    endtask

    task automatic t_sat_bottom();
        preset(1, 9, 9, 9);
        select_and_cmd(0);
        pulse(0); pulse(0); pulse(0);
        check_bank("R6 saturate at 0", 0, 9, 9, 9);
        pulse(1);
        check_bank("R6 step up from 0", 1, 9, 9, 9);
        deselect();
    endtask

    task automatic t_mixed();
        preset(50, 60, 33, 70);
        select_and_cmd(2);
        pulse(1); pulse(1); pulse(0); pulse(1); pulse(0); pulse(0); pulse(0);
        check("R10 strobe count", upd_count, 7);
        check_bank("R10 mixed sequence", 50, 60, 32, 70);
        deselect();
    endtask

    task automatic t_disarm();
        preset(100, 100, 100, 100);
        select_and_cmd(1);
        pulse(1);
        deselect();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        pulse(1); pulse(0); pulse(1);
        check_bank("R8 no steps after deselect", 100, 101, 100, 100);
        check("R8 strobe count", upd_count, 1);
        deselect();
        select_and_cmd(1);
        pulse(0); pulse(0);
        check_bank("R8 resumes after new command", 100, 99, 100, 100);
        deselect();
    endtask

    initial begin
        rst = 1'b1; sck = 1'b0; si = 1'b0; cs_n = 1'b1;
        cmd_valid = 1'b0; cmd_pot = 2'd0; upd_count = 0;
        for (int i = 0; i < 4; i++) bank[i] = 8'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_idle();
        t_cmd_while_deselected();
        t_increment();
        t_decrement();
        t_long_high();
        t_sat_top();
        t_sat_bottom();
        t_mixed();
        t_disarm();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule